// File: doc/BRIEF.md
# Stepwise Shutdown Trip Sequencer

This block turns redundant Boolean trip requests from a process into one shutdown drive line that pulses. Temperature, pressure and water-inflow requests are each voted in their own group. A signal that carries its fault flag is counted as inactive. The three group results are ORed into a combined process trip. On the time-step tick where that trip appears, the output goes high for a short fixed pulse. A longer cycle timer then holds off any new pulse. Once the cycle timer is idle again, the block pulses again if the process trip is still present. A pair of manual pushbuttons feeds its own pulse timer, whose output is ORed straight onto the drive line.

Every timer advances only on `tick_i`, which the surrounding logic asserts for one clock per time step. All durations are parameters counted in ticks. The defaults are 3, 15 and 5 ticks, for one tick per second. Each pulse timer starts only on a rising edge of its input, and only while it is idle. The manual path resets nothing. A manual press can therefore never stop the process cycle from re-arming.

Top module: `ssd_trip_seq`

## Requirements
- R1: The temperature group trips when at least TEMP_K (default 2) of the N_TEMP (default 4) temperature signals are active and not faulted. With fewer active, it does not trip.
- R2: The pressure group trips when either bit of `press_i` is active and not faulted.
- R3: The inflow group trips only after at least one non-faulted bit of `flow_i` has been high on FLOW_TICKS consecutive ticks. A tick with no such bit restarts the count. The output pulse begins on the tick after the count completes.
- R4: A signal whose fault bit (same bit position) is 1 counts as inactive. A group whose signals are all faulted contributes 0.
- R5: When the combined process trip rises on a tick while the cycle timer is idle, `trip_o` is high from that tick on for exactly PULSE_TICKS ticks.
- R6: After a pulse, `trip_o` stays low until the cycle timer (CYCLE_TICKS ticks) has expired. If the process trip is still active on the first tick after that, a new pulse starts, so the pulses repeat every CYCLE_TICKS+1 ticks. If the trip is gone by then, no pulse follows.
- R7: Pulse timers do not retrigger. An input held high, or a new rising edge while a timer is running, does not lengthen or restart its pulse.
- R8: A rising edge of the 1-out-of-2 vote of `man_i` drives `trip_o` high for PULSE_TICKS ticks. It does not disturb the process cycle, so a press during a process pulse does not stop the next scheduled process pulse.
- R9: While `rst_ni` is low, all timers and edge registers are cleared and `trip_o` is 0, even in the middle of a pulse.
- R10: State and `trip_o` change only on clock edges where `tick_i` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-clock time-step strobe |
| temp_i | input | N_TEMP | Temperature over-limit signals |
| temp_flt_i | input | N_TEMP | Fault flags for temp_i, bit for bit |
| press_i | input | 2 | Over-pressure signals |
| press_flt_i | input | 2 | Fault flags for press_i |
| flow_i | input | 2 | High water-inflow signals |
| flow_flt_i | input | 2 | Fault flags for flow_i |
| man_i | input | 2 | Manual trip pushbuttons |
| trip_o | output | 1 | Shutdown drive |

## Verification
The bench builds the block with its defaults: four temperature signals with a threshold of two, and timer lengths of 3, 15 and 5 ticks. It strobes the tick every fourth clock. With these values, a complete pulse, the 13-tick gap and the repeat pulse at tick 17 all fit in a few dozen ticks. The bench compares every tick of that sequence exactly. This includes the case where a manual press lands inside a process pulse and the later repeat must still appear. The 5-tick inflow wait is also short enough to interrupt at 4 ticks and to complete.

// File: rtl/ssd_pkg.sv
package ssd_pkg;
  localparam int unsigned DEF_PULSE_TICKS = 3;
  localparam int unsigned DEF_CYCLE_TICKS = 15;
  localparam int unsigned DEF_FLOW_TICKS  = 5;
  localparam int unsigned DEF_N_TEMP      = 4;
  localparam int unsigned DEF_TEMP_K      = 2;

  function automatic int unsigned cnt_w(input int unsigned len);
    return (len < 1) ? 1 : $clog2(len + 1);
  endfunction
endpackage

// File: rtl/ssd_vote.sv
module ssd_vote #(
  parameter int unsigned N = 2,
  parameter int unsigned K = 1
) (
  input  logic [N-1:0] sig_i,
  input  logic [N-1:0] flt_i,
  output logic         hit_o
);
  logic [N-1:0] valid;

  // faulted signals count as inactive
  assign valid = sig_i & ~flt_i;
  assign hit_o = ($countones(valid) >= K);
endmodule

// File: rtl/ssd_persist.sv
module ssd_persist
  import ssd_pkg::*;
#(
  parameter int unsigned LEN = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic in_i,
  output logic held_o
);
  localparam int unsigned CW = cnt_w(LEN);
  localparam logic [CW-1:0] LIM = CW'(LEN);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (tick_i) begin
      if (!in_i)            cnt_q <= '0;
      else if (cnt_q < LIM) cnt_q <= cnt_q + CW'(1);
    end
  end

  assign held_o = (cnt_q == LIM);
endmodule

// File: rtl/ssd_pulse.sv
module ssd_pulse
  import ssd_pkg::*;
#(
  parameter int unsigned LEN = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic in_i,
  output logic on_o
);
  localparam int unsigned CW = cnt_w(LEN);
  localparam logic [CW-1:0] LIM = CW'(LEN);

  logic [CW-1:0] cnt_q;
  logic          in_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      in_q  <= 1'b0;
    end else if (tick_i) begin
      in_q <= in_i;
      if (cnt_q >= LIM)         cnt_q <= '0;
      else if (cnt_q != '0)     cnt_q <= cnt_q + CW'(1);
      else if (in_i && !in_q)   cnt_q <= CW'(1);  // idle and rising edge only
    end
  end

  assign on_o = (cnt_q != '0);
endmodule

// File: rtl/ssd_trip_seq.sv
module ssd_trip_seq
  import ssd_pkg::*;
#(
  parameter int unsigned N_TEMP      = DEF_N_TEMP,
  parameter int unsigned TEMP_K      = DEF_TEMP_K,
  parameter int unsigned PULSE_TICKS = DEF_PULSE_TICKS,
  parameter int unsigned CYCLE_TICKS = DEF_CYCLE_TICKS,
  parameter int unsigned FLOW_TICKS  = DEF_FLOW_TICKS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [N_TEMP-1:0] temp_i,
  input  logic [N_TEMP-1:0] temp_flt_i,
  input  logic [1:0]        press_i,
  input  logic [1:0]        press_flt_i,
  input  logic [1:0]        flow_i,
  input  logic [1:0]        flow_flt_i,
  input  logic [1:0]        man_i,
  output logic              trip_o
);
  logic temp_hit, press_hit, flow_hit, flow_held, man_hit;
  logic proc_trip, gate, cyc_on, out_on, man_on;

  ssd_vote #(.N(N_TEMP), .K(TEMP_K)) u_temp (
    .sig_i(temp_i), .flt_i(temp_flt_i), .hit_o(temp_hit));

  ssd_vote #(.N(2), .K(1)) u_press (
    .sig_i(press_i), .flt_i(press_flt_i), .hit_o(press_hit));

  ssd_vote #(.N(2), .K(1)) u_flow (
    .sig_i(flow_i), .flt_i(flow_flt_i), .hit_o(flow_hit));

  ssd_vote #(.N(2), .K(1)) u_man (
    .sig_i(man_i), .flt_i(2'b00), .hit_o(man_hit));

  ssd_persist #(.LEN(FLOW_TICKS)) u_flow_dly (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i),
    .in_i(flow_hit), .held_o(flow_held));

  assign proc_trip = temp_hit | press_hit | flow_held;
  // the cycle timer's falling edge re-opens the gate
  assign gate      = proc_trip & ~cyc_on;

  ssd_pulse #(.LEN(CYCLE_TICKS)) u_cycle (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i),
    .in_i(gate), .on_o(cyc_on));

  ssd_pulse #(.LEN(PULSE_TICKS)) u_out (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i),
    .in_i(gate), .on_o(out_on));

  ssd_pulse #(.LEN(PULSE_TICKS)) u_manp (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i),
    .in_i(man_hit), .on_o(man_on));

  assign trip_o = out_on | man_on;
endmodule

// File: rtl/ssd_trip_seq_chk.sv
module ssd_trip_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       tick_i,
  input logic [1:0] man_i,
  input logic       trip_o,
  input logic       proc_trip,
  input logic       cyc_on,
  input logic       out_on,
  input logic       man_on
);
  logic man_prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     man_prev_q <= 1'b0;
    else if (tick_i) man_prev_q <= |man_i;
  end

  p_tick_only_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(trip_o));

  p_pulse_in_cycle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_on |-> cyc_on);

  p_start_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && proc_trip && !cyc_on) |=> (out_on && trip_o));

  p_man_start_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && (|man_i) && !man_prev_q && !man_on) |=> (man_on && trip_o));

  always @(posedge clk_i) begin
    if (!rst_ni) p_reset_low_r9: assert (!trip_o);
  end
endmodule

bind ssd_trip_seq ssd_trip_seq_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .man_i(man_i),
  .trip_o(trip_o), .proc_trip(proc_trip), .cyc_on(cyc_on),
  .out_on(out_on), .man_on(man_on));

// File: tb/sim_ssd_trip_seq.sv
module sim_ssd_trip_seq;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b0;
  logic [3:0] temp_i = '0, temp_flt_i = '0;
  logic [1:0] press_i = '0, press_flt_i = '0;
  logic [1:0] flow_i = '0, flow_flt_i = '0;
  logic [1:0] man_i = '0;
  logic       trip_o;

  int checks = 0;
  int errors = 0;
  bit    exp_q[$];
  string tag_q[$];

  always #10 clk = ~clk;  // 50 MHz

  ssd_trip_seq u0 (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick_i),
    .temp_i(temp_i), .temp_flt_i(temp_flt_i),
    .press_i(press_i), .press_flt_i(press_flt_i),
    .flow_i(flow_i), .flow_flt_i(flow_flt_i),
    .man_i(man_i), .trip_o(trip_o));

  task automatic check(input bit got, input bit exp, input string tag);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: trip_o=%0b expected %0b at %0t", tag, got, exp, $time);
    end
  endtask

  // driver: one tick, expected output after it queued for the monitor
  task automatic step(input bit exp, input string tag);
    @(negedge clk);
    tick_i = 1'b1;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    tick_i = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic steps(input int n, input bit exp, input string tag);
    for (int i = 0; i < n; i++) step(exp, tag);
  endtask

  // monitor
  always @(posedge clk) begin
    if (tick_i && rst_ni) begin
      #2;
      if (exp_q.size() == 0) begin
        check(trip_o, 1'b0, "scoreboard-empty");
      end else begin
        check(trip_o, exp_q.pop_front(), tag_q.pop_front());
      end
    end
  end

  task automatic do_reset();
    @(negedge clk);
    temp_i = '0; temp_flt_i = '0; press_i = '0; press_flt_i = '0;
    flow_i = '0; flow_flt_i = '0; man_i = '0;
    rst_ni = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check(trip_o, 1'b0, "R9 reset");
    rst_ni = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R9: reset with inputs active
    temp_i = 4'b1111; man_i = 2'b11;
    repeat (3) @(negedge clk);
    check(trip_o, 1'b0, "R9 inputs during reset");

    // R5/R6: pulse, hold-off, repeat, stop when cleared
    do_reset();
    temp_i = 4'b0011;
    steps(3, 1'b1, "R5 pulse");
    steps(13, 1'b0, "R6 hold-off");
    steps(3, 1'b1, "R6 repeat");
    temp_i = 4'b0000;
    steps(16, 1'b0, "R6 no repeat after clear");

    // R1: temperature threshold
    do_reset();
    temp_i = 4'b0001;
    steps(3, 1'b0, "R1 single temp");
    temp_i = 4'b1001;
    step(1'b1, "R1 two temps");

    // R4: faults mask signals
    do_reset();
    temp_i = 4'b0011; temp_flt_i = 4'b0010;
    steps(2, 1'b0, "R4 temp masked");
    press_i = 2'b11; press_flt_i = 2'b11;
    steps(2, 1'b0, "R4 press all faulted");
    flow_i = 2'b11; flow_flt_i = 2'b11;
    steps(6, 1'b0, "R4 flow all faulted");
    temp_flt_i = 4'b0000;
    step(1'b1, "R4 fault cleared");

    // R2: pressure 1oo2
    do_reset();
    press_i = 2'b01;
    step(1'b1, "R2 press bit0");
    do_reset();
    press_i = 2'b10;
    step(1'b1, "R2 press bit1");

    // R3: inflow persistence
    do_reset();
    flow_i = 2'b10;
    steps(4, 1'b0, "R3 four ticks");
    flow_i = 2'b00;
    step(1'b0, "R3 gap");
    flow_i = 2'b01;
    steps(5, 1'b0, "R3 counting");
    step(1'b1, "R3 trip after persist");

    // R8/R7: manual pulse, held button no retrigger
    do_reset();
    man_i = 2'b01;
    steps(3, 1'b1, "R8 manual pulse");
    steps(2, 1'b0, "R7 held no retrigger");
    man_i = 2'b00;
    step(1'b0, "R8 released");
    man_i = 2'b10;
    step(1'b1, "R8 second press");

    // R7: edge during running pulse ignored
    do_reset();
    temp_i = 4'b0011;
    step(1'b1, "R7 start");
    temp_i = 4'b0000;
    step(1'b1, "R7 run");
    temp_i = 4'b0011;
    step(1'b1, "R7 edge while busy");
    temp_i = 4'b0000;
    steps(3, 1'b0, "R7 no extension");

    // R8: manual press mid-pulse must not lock output low
    do_reset();
    temp_i = 4'b0011;
    step(1'b1, "R8 proc pulse");
    man_i = 2'b01;
    steps(2, 1'b1, "R8 overlap");
    step(1'b1, "R8 manual tail");
    man_i = 2'b00;
    steps(12, 1'b0, "R8 hold-off");
    steps(3, 1'b1, "R8 repeat not locked");

    // R10: nothing moves without tick
    do_reset();
    temp_i = 4'b0011;
    repeat (10) @(negedge clk);
    check(trip_o, 1'b0, "R10 no tick");
    step(1'b1, "R10 first tick");

    // R9: async reset mid-pulse, restart after release
    @(negedge clk);
    rst_ni = 1'b0;
    #1;
    check(trip_o, 1'b0, "R9 mid-pulse reset");
    @(negedge clk);
    rst_ni = 1'b1;
    step(1'b1, "R9 restart after reset");

    repeat (4) @(negedge clk);
    if (exp_q.size() != 0) check(1'b1, 1'b0, "scoreboard-leftover");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule